// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit

This block is a multicycle arithmetic engine for the datapath of a small processor core. It performs three operations: an 8-by-8 unsigned multiply that gives a 16-bit product, an unsigned 16-by-16 integer divide that gives a quotient and a remainder, and a fractional divide. In the fractional divide, both 16-bit operands are read as binary fractions below one. The result is a 16-bit fractional quotient and a remainder. Instruction decode and register write-back sit outside the block.

The caller presents an operation code and two operand words and raises `start` for one cycle while `busy` is low. The unit captures the operands and holds `busy` high while it iterates. It then pulses `done` for one cycle, with the results and the carry, overflow and zero flags valid. The results stay on the outputs until the next operation completes. The two divides take a fixed number of cycles, set by a parameter, so that software timing is the same for every operand value. The multiply is shorter.

Top module: `mdu_top`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `done` are 0, both result words are 0 and all three flags are 0.
- R2: With `op` = 2'b00 (multiply), the product of the low 8 bits of `opnd_a` and `opnd_b` appears on `result_q`, with the high byte in bits 15:8. `result_r` is 0. `flag_c` equals bit 7 of the product, and `flag_v` and `flag_z` are 0. The upper operand bits are ignored. Example: 0x20 × 0x35 gives 0x06A0 with carry 1.
- R3: With `op` = 2'b01 (integer divide) and a nonzero divisor in `opnd_b`, `result_q` = `opnd_a` / `opnd_b` and `result_r` = `opnd_a` mod `opnd_b`. `flag_c` and `flag_v` are 0, and `flag_z` is 1 exactly when the quotient is 0. Example: 6 / 4 gives 1, remainder 2.
- R4: An integer divide by zero gives quotient 0xFFFF and remainder equal to the dividend, with `flag_c` = 1, `flag_v` = 0 and `flag_z` = 0.
- R5: With `op` = 2'b10 (fractional divide), when 0 < numerator `opnd_a` < denominator `opnd_b`, `result_q` = floor(a·2^16 / b) and `result_r` = (a·2^16) mod b. `flag_c` and `flag_v` are 0, and `flag_z` marks a zero quotient. Example: 2 over 4 gives 0x8000, remainder 0.
- R6: A fractional divide with a nonzero denominator that is not greater than the numerator gives quotient 0xFFFF and remainder equal to the numerator, with `flag_v` = 1 and `flag_c` = 0.
- R7: A fractional divide with a zero denominator gives quotient 0xFFFF and remainder equal to the numerator, with `flag_c` = 1 and `flag_v` = 0.
- R8: Counted from the clock edge that accepts `start`, `done` is a single-cycle pulse on the 41st edge for both divides and on the 9th edge for the multiply. `busy` is high from the edge after acceptance through that edge, and it falls on the same edge that raises `done`.
- R9: A `start` raised while `busy` is high is ignored: the running operation's results and its completion time do not change, and no second operation follows.
- R10: A `start` with `op` = 2'b11 is ignored: `busy` and `done` stay low and the outputs are unchanged.
- R11: The result words and flags change only on the cycle where `done` is high, and they hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, taken only when idle |
| op | input | 2 | 00 multiply, 01 integer divide, 10 fractional divide, 11 reserved |
| opnd_a | input | 16 | Multiplicand (low byte) / dividend / numerator |
| opnd_b | input | 16 | Multiplier (low byte) / divisor / denominator |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result_q | output | 16 | Product or quotient |
| result_r | output | 16 | Remainder (0 for multiply) |
| flag_c | output | 1 | Carry: product bit 7 or divide by zero |
| flag_v | output | 1 | Overflow of fractional divide |
| flag_z | output | 1 | Quotient is zero |

## Verification
The bench builds the unit with its default values, a 16-bit word and a 41-cycle divide. This puts the multiply's whole 8-bit operand space and the 0xFFFF saturation boundaries in easy reach of random stimulus. The random mix is biased toward zero, equal and swapped operands, so that the divide-by-zero, fractional-overflow and zero-quotient paths come up repeatedly. Directed cases repeat the worked examples. Extra `start` pulses are injected during busy periods to confirm that the completion cycle and the results stay undisturbed.

// File: rtl/mdu_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the multiply/divide unit.
// Assumes op codes are two bits wide and that code 3 is reserved.
package mdu_pkg;

    typedef enum logic [1:0] {
        OP_MUL  = 2'b00,
        OP_IDIV = 2'b01,
        OP_FDIV = 2'b10,
        OP_NONE = 2'b11
    } mdu_op_e;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic zero;
    } mdu_flags_t;

endpackage

// File: rtl/mdu_ctrl.sv
`timescale 1ns/1ps
// Sequencer: accepts a request when idle, counts cycles, issues step
// strobes to the cores and a finish strobe on the last cycle.
// Assumes DIV_LAT >= MUL_LAT and that each latency exceeds its iteration count.
module mdu_ctrl
    import mdu_pkg::*;
#(
    parameter int MUL_ITER = 8,
    parameter int MUL_LAT  = 9,
    parameter int DIV_ITER = 16,
    parameter int DIV_LAT  = 41
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  mdu_op_e op_in,
    output logic    accept,
    output logic    busy,
    output logic    done,
    output logic    step_mul,
    output logic    step_div,
    output logic    finish,
    output mdu_op_e op_q
);
    localparam int CNT_W = $clog2(DIV_LAT + 1);
    localparam logic [CNT_W-1:0] MUL_LAST = CNT_W'(MUL_LAT - 1);
    localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(DIV_LAT - 1);
    localparam logic [CNT_W-1:0] MUL_STEPS = CNT_W'(MUL_ITER);
    localparam logic [CNT_W-1:0] DIV_STEPS = CNT_W'(DIV_ITER);

    logic [CNT_W-1:0] cnt;
    logic             is_mul;

    // Decode the acceptance, step and finish strobes from the counter
    always_comb begin
        accept   = start && !busy && (op_in != OP_NONE);
        is_mul   = (op_q == OP_MUL);
        finish   = busy && (cnt == (is_mul ? MUL_LAST : DIV_LAST));
        step_mul = busy && is_mul && (cnt < MUL_STEPS);
        step_div = busy && !is_mul && (cnt < DIV_STEPS);
    end

    // Track busy state, the cycle count and the completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            op_q <= OP_MUL;
        end else begin
            done <= finish;
            if (accept) begin
                busy <= 1'b1;
                cnt  <= '0;
                op_q <= op_in;
            end else if (finish) begin
                busy <= 1'b0;
            end else if (busy) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mdu_mul_core.sv
`timescale 1ns/1ps
// Shift-add unsigned multiplier: one multiplier bit per step, LSB first.
// Assumes exactly HALF_W steps follow a load before the product is read.
module mdu_mul_core #(
    parameter int HALF_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                step,
    input  logic [HALF_W-1:0]   mcand_in,
    input  logic [HALF_W-1:0]   mplier_in,
    output logic [2*HALF_W-1:0] product
);
    logic [HALF_W-1:0] hi, lo, mcand;
    logic [HALF_W:0]   sum;

    // Add the multiplicand to the upper half when the current bit is set
    always_comb begin
        sum = {1'b0, hi} + (lo[0] ? {1'b0, mcand} : '0);
    end

    // Load operands, then shift the partial product right each step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi    <= '0;
            lo    <= '0;
            mcand <= '0;
        end else if (load) begin
            hi    <= '0;
            lo    <= mplier_in;
            mcand <= mcand_in;
        end else if (step) begin
            hi <= sum[HALF_W:1];
            lo <= {sum[0], lo[HALF_W-1:1]};
        end
    end

    assign product = {hi, lo};

endmodule

// File: rtl/mdu_div_core.sv
`timescale 1ns/1ps
// Restoring shift-subtract divider, one quotient bit per step.
// Integer mode divides the word; fractional mode divides the word shifted
// left by W (numerator preloaded as the partial remainder).
// Assumes W steps follow a load; zero divisor and fractional overflow
// are resolved by the caller.
module mdu_div_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         frac,
    input  logic         step,
    input  logic [W-1:0] dvd_in,
    input  logic [W-1:0] dvs_in,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    logic [W-1:0] rem, quo, dvs_q;
    logic [W:0]   shifted, diff;
    logic         fits;

    // Trial subtraction of the divisor from the shifted partial remainder
    always_comb begin
        shifted = {rem, quo[W-1]};
        diff    = shifted - {1'b0, dvs_q};
        fits    = (shifted >= {1'b0, dvs_q});
    end

    // Load the operands, then produce one quotient bit per step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem   <= '0;
            quo   <= '0;
            dvs_q <= '0;
        end else if (load) begin
            rem   <= frac ? dvd_in : '0;
            quo   <= frac ? '0 : dvd_in;
            dvs_q <= dvs_in;
        end else if (step) begin
            rem <= fits ? diff[W-1:0] : shifted[W-1:0];
            quo <= {quo[W-2:0], fits};
        end
    end

    assign quotient  = quo;
    assign remainder = rem;

endmodule

// File: rtl/mdu_top.sv
`timescale 1ns/1ps
// Multicycle multiply / integer divide / fractional divide unit.
// A request is taken when idle; results and flags are registered on the
// completion cycle and held until the next completion.
// Assumes WORD_W is even; the multiply uses the low half of each operand.
module mdu_top
    import mdu_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int DIV_CYCLES = 41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [WORD_W-1:0] opnd_a,
    input  logic [WORD_W-1:0] opnd_b,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] result_q,
    output logic [WORD_W-1:0] result_r,
    output logic              flag_c,
    output logic              flag_v,
    output logic              flag_z
);
    localparam int HALF_W  = WORD_W / 2;
    localparam int MUL_LAT = HALF_W + 1;
    localparam int DIV_LAT = (DIV_CYCLES > WORD_W) ? DIV_CYCLES : WORD_W + 1;

    mdu_op_e           op_in, op_q;
    logic              accept, step_mul, step_div, finish;
    logic [WORD_W-1:0] a_q, b_q;
    logic [WORD_W-1:0] product, div_q, div_r;
    logic [WORD_W-1:0] nxt_q, nxt_r;
    mdu_flags_t        nxt_f;

    assign op_in = mdu_op_e'(op);

    mdu_ctrl #(
        .MUL_ITER (HALF_W),
        .MUL_LAT  (MUL_LAT),
        .DIV_ITER (WORD_W),
        .DIV_LAT  (DIV_LAT)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_in    (op_in),
        .accept   (accept),
        .busy     (busy),
        .done     (done),
        .step_mul (step_mul),
        .step_div (step_div),
        .finish   (finish),
        .op_q     (op_q)
    );

    mdu_mul_core #(.HALF_W(HALF_W)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .step      (step_mul),
        .mcand_in  (opnd_a[HALF_W-1:0]),
        .mplier_in (opnd_b[HALF_W-1:0]),
        .product   (product)
    );

    mdu_div_core #(.W(WORD_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .frac      (op_in == OP_FDIV),
        .step      (step_div),
        .dvd_in    (opnd_a),
        .dvs_in    (opnd_b),
        .quotient  (div_q),
        .remainder (div_r)
    );

    // Keep the operands for edge-case resolution at completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (accept) begin
            a_q <= opnd_a;
            b_q <= opnd_b;
        end
    end

    // Select the final result and flags, covering zero divisor and overflow
    always_comb begin
        nxt_q = div_q;
        nxt_r = div_r;
        nxt_f = '0;
        unique case (op_q)
            OP_MUL: begin
                nxt_q       = product;
                nxt_r       = '0;
                nxt_f.carry = product[HALF_W-1];
            end
            OP_IDIV: begin
                if (b_q == '0) begin
                    nxt_q       = '1;
                    nxt_r       = a_q;
                    nxt_f.carry = 1'b1;
                end
                nxt_f.zero = (nxt_q == '0);
            end
            default: begin
                if (b_q == '0) begin
                    nxt_q       = '1;
                    nxt_r       = a_q;
                    nxt_f.carry = 1'b1;
                end else if (a_q >= b_q) begin
                    nxt_q     = '1;
                    nxt_r     = a_q;
                    nxt_f.ovf = 1'b1;
                end
                nxt_f.zero = (nxt_q == '0);
            end
        endcase
    end

    // Register results and flags on the completion cycle only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            result_r <= '0;
            flag_c   <= 1'b0;
            flag_v   <= 1'b0;
            flag_z   <= 1'b0;
        end else if (finish) begin
            result_q <= nxt_q;
            result_r <= nxt_r;
            flag_c   <= nxt_f.carry;
            flag_v   <= nxt_f.ovf;
            flag_z   <= nxt_f.zero;
        end
    end

endmodule

// File: rtl/mdu_checker.sv
`timescale 1ns/1ps
// Protocol and result checker for mdu_top, attached by bind.
// Counts cycles from acceptance to check completion latency.
module mdu_checker #(
    parameter int WORD_W     = 16,
    parameter int DIV_CYCLES = 41
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        op,
    input logic              busy,
    input logic              done,
    input logic [WORD_W-1:0] result_q,
    input logic [WORD_W-1:0] result_r,
    input logic              flag_c,
    input logic              flag_v,
    input logic              flag_z
);
    localparam int MUL_LAT = WORD_W / 2 + 1;
    localparam int DIV_LAT = (DIV_CYCLES > WORD_W) ? DIV_CYCLES : WORD_W + 1;
    localparam int CW      = $clog2(DIV_LAT + 1) + 1;

    logic [CW-1:0] lat_cnt;

    // Count busy cycles since the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n)                                 lat_cnt <= '0;
        else if (start && !busy && (op != 2'b11))   lat_cnt <= '0;
        else if (busy)                              lat_cnt <= lat_cnt + 1'b1;
    end

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == CW'(MUL_LAT) || lat_cnt == CW'(DIV_LAT)));

    assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op == 2'b11) |=> !busy);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result_q) && $stable(result_r) && $stable(flag_c)
                   && $stable(flag_v) && $stable(flag_z)));

    assert_ovf_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_v) |-> (result_q == '1 && !flag_c));

    assert_zero_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_z) |-> (result_q == '0));

endmodule

bind mdu_top mdu_checker #(.WORD_W(WORD_W), .DIV_CYCLES(DIV_CYCLES)) u_chk (.*);

// File: tb/mdu_top_bench.sv
`timescale 1ns/1ps
module mdu_top_bench;
    localparam int W   = 16;
    localparam int H   = W / 2;
    localparam int DLAT = 41;
    localparam int MLAT = H + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   op = 2'b00;
    logic [W-1:0] opnd_a = '0, opnd_b = '0;
    logic         busy, done, flag_c, flag_v, flag_z;
    logic [W-1:0] result_q, result_r;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mdu_top #(.WORD_W(W), .DIV_CYCLES(DLAT)) u_mdu_top (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model built from the requirements
    task automatic model(input logic [1:0] o, input logic [W-1:0] a, b,
                         output logic [W-1:0] q, r,
                         output logic c, v, z, output int lat);
        logic [2*W-1:0] num;
        c = 0; v = 0; z = 0;
        if (o == 2'b00) begin
            q = W'(a[H-1:0] * b[H-1:0]);
            r = '0; c = q[H-1]; lat = MLAT;
        end else begin
            lat = DLAT;
            if (b == 0) begin
                q = '1; r = a; c = 1;
            end else if (o == 2'b01) begin
                q = a / b; r = a % b;
            end else if (a >= b) begin
                q = '1; r = a; v = 1;
            end else begin
                num = {a, {W{1'b0}}};
                q = W'(num / b); r = W'(num % b);
            end
            z = (q == 0);
        end
    endtask

    function automatic string req_of(input logic [1:0] o, input logic [W-1:0] a, b);
        if (o == 2'b00) return "R2";
        if (b == 0) return (o == 2'b01) ? "R4" : "R7";
        if (o == 2'b01) return "R3";
        return (a >= b) ? "R6" : "R5";
    endfunction

    // Issue one operation, optionally disturb it, and check everything
    task automatic run(input logic [1:0] o, input logic [W-1:0] a, b, input bit disturb);
        logic [W-1:0] eq, er;
        logic ec, ev, ez;
        int elat, n;
        string rq;
        model(o, a, b, eq, er, ec, ev, ez, elat);
        rq = req_of(o, a, b);
        @(negedge clk);
        start = 1; op = o; opnd_a = a; opnd_b = b;
        @(negedge clk);
        start = 0;
        n = 0;
        chk("R8", "busy after accept", busy, 1);
        if (disturb) begin
            start = 1; op = ~o; opnd_a = ~a; opnd_b = b ^ 16'h5A5A;  // R9 ignored request
        end
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
            start = 0;
            opnd_a = $urandom; opnd_b = $urandom;
        end
        chk(disturb ? "R9" : "R8", "latency", n, elat);
        chk("R8", "busy low at done", busy, 0);
        chk(rq, "quotient/product", result_q, eq);
        chk(rq, "remainder", result_r, er);
        chk(rq, "flags cvz", {ec, ev, ez} == {flag_c, flag_v, flag_z} ? 1 : {flag_c, flag_v, flag_z}, 1);
        @(negedge clk);
        chk("R8", "done single pulse", done, 0);
        chk("R11", "result held", {result_q, result_r}, {eq, er});
        if (disturb) chk("R9", "no second operation", busy, 0);
    endtask

    initial begin
        void'($urandom(32'd7719));
        repeat (5) @(negedge clk);
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "results", {result_q, result_r}, 0);
        chk("R1", "flags", {flag_c, flag_v, flag_z}, 0);
        rst_n = 1;

        run(2'b00, 16'hFF20, 16'hAB35, 0);   // R2 0x20*0x35 = 0x06A0, C=1
        chk("R2", "example product", result_q, 16'h06A0);
        chk("R2", "example carry", flag_c, 1);
        run(2'b00, 16'h00FF, 16'h00FF, 0);   // R2 max
        run(2'b00, 16'h0000, 16'h0037, 0);   // R2 zero
        run(2'b01, 16'd6, 16'd4, 0);         // R3 example
        chk("R3", "example quotient", result_q, 1);
        chk("R3", "example remainder", result_r, 2);
        run(2'b01, 16'd3, 16'd9, 0);         // R3 zero quotient
        chk("R3", "zero flag", flag_z, 1);
        run(2'b01, 16'hFFFF, 16'h0001, 0);   // R3
        run(2'b01, 16'h1234, 16'h0000, 0);   // R4
        run(2'b10, 16'd2, 16'd4, 0);         // R5 example
        chk("R5", "example quotient", result_q, 16'h8000);
        run(2'b10, 16'h0001, 16'hFFFF, 0);   // R5
        run(2'b10, 16'h4000, 16'h4000, 0);   // R6 equal
        run(2'b10, 16'h9000, 16'h0003, 0);   // R6
        run(2'b10, 16'h0042, 16'h0000, 0);   // R7
        run(2'b01, 16'd1000, 16'd7, 1);      // R9 disturb divide
        run(2'b00, 16'h0013, 16'h0077, 1);   // R9 disturb multiply

        // R10: reserved op code is ignored
        @(negedge clk);
        start = 1; op = 2'b11; opnd_a = 16'h1111; opnd_b = 16'h2222;
        @(negedge clk);
        start = 0;
        chk("R10", "busy stays low", busy, 0);
        repeat (3) @(negedge clk);
        chk("R10", "no done", done, 0);
        chk("R10", "outputs unchanged", result_q, W'(16'h13 * 16'h77));

        for (int i = 0; i < 150; i++) begin
            logic [1:0] o;
            logic [W-1:0] a, b, t;
            o = 2'($urandom_range(0, 2));
            a = $urandom; b = $urandom;
            case ($urandom % 8)
                0: b = 0;
                1: b = a;
                2: b = W'($urandom % 16);
                3: if (a > b) begin t = a; a = b; b = t; end
                default: ;
            endcase
            run(o, a, b, ($urandom % 10) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL R8 watchdog expired actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule